// File: doc/BRIEF.md
# Ethernet Controller Interrupt and Transmit/Receive Control Registers

This block is the host-visible register slice of a simple Ethernet controller. It keeps a sticky interrupt status word fed by the receive and transmit engines, and an interrupt enable word. It drives a level interrupt that is high whenever an enabled status bit is pending. The host acknowledges causes by writing ones to the status word.

A combined transmit/receive control register decodes each written value. An exact value starts the transmit engine with a single-cycle kick. Certain bits force the idle state, pulse a ring-index reset, or wipe all pending interrupts. A zero write can complete a setup handshake into a neighbouring register instead of being stored. The idle flag follows the DMA engine's busy signal. A ring-geometry register is split into transmit and receive ring lengths. Every other word-aligned offset behaves as plain read/write storage.

Top module: `nic_csr_ctrl`

## Requirements
- R1: Synchronous reset clears every register and every storage word. After reset `irq`, `tx_kick`, `ring_rst` and `trx_idle` are 0, both ring lengths are 1, and all reads return 0.
- R2: The clock edge that updates the status or enable word also updates `irq`. `irq` equals the OR of (status AND enable), with status at offset 0x000 and enable at offset 0x004.
- R3: A host write to offset 0x000 clears each status bit written as 1 and keeps the others. An event arriving in the same cycle still sets its bit.
- R4: Each event input sets one status bit on the following edge. The bits are: receive done bit 1, receive no-buffer bit 2, transmit error bit 3, transmit done bit 4, timer bit 5, management event bit 6.
- R5: A write of exactly 0x00000001 to offset 0x144 gives a one-cycle `tx_kick` pulse in the cycle after the write, and stores the value. No other value pulses `tx_kick`.
- R6: A control write with bit 2 set makes the control register exactly 0x00000008. It causes no ring reset and no status clear.
- R7: A control write with bit 4 set and bit 2 clear gives a one-cycle `ring_rst` pulse in the cycle after the write.
- R8: A control write with bit 1 set and bit 2 clear zeroes the status word, and leaves the control register unchanged. Events in that cycle still set their bits.
- R9: A control write of 0 while the word at 0x134 holds 0x00200010 sets the word at 0x130 to 0x80000000, and leaves the control register unchanged. Otherwise a 0 is stored.
- R10: `trx_idle` is control bit 3. A rising edge on `dma_busy` clears it on the next clock, and a falling edge sets it. The DMA edge overrides bit 3 of a host write in the same cycle.
- R11: The register at 0x108 gives `tx_ring_len` = bits [15:0] + 1 and `rx_ring_len` = bits [31:16] + 1. The lengths change only on a write there.
- R12: Reads are combinational and address bits [1:0] are ignored. Offsets 0x000, 0x004, 0x108, 0x130, 0x134 and 0x144 read their registers. Any other offset reads the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | ADDR_W | Host read byte address |
| rd_data | output | 32 | Read data for `rd_addr` |
| ev_rx_done | input | 1 | Frame received event |
| ev_rx_nobuf | input | 1 | No receive buffer event |
| ev_tx_err | input | 1 | Transmit error event |
| ev_tx_done | input | 1 | Transmit completed event |
| ev_timer | input | 1 | Timer event |
| ev_mii | input | 1 | Management interface event |
| dma_busy | input | 1 | DMA engine busy level |
| irq | output | 1 | Level interrupt |
| tx_kick | output | 1 | One-cycle transmit start |
| ring_rst | output | 1 | One-cycle ring index reset |
| trx_idle | output | 1 | Idle flag (control bit 3) |
| tx_ring_len | output | RING_W+1 | Transmit ring length |
| rx_ring_len | output | RING_W+1 | Receive ring length |

## Verification
The bench builds the block with ADDR_W = 10 and RING_W = 16. With ADDR_W = 10, all 256 words up to offset 0x3FC are reachable, so plain storage words can be written on either side of the decoded offsets. With RING_W = 16, an all-ones ring register gives the largest length, 0x10000, on both rings. A random phase mixes control values, event pulses and busy edges, so same-cycle interactions are exercised against the bench's behavioural model.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int WORD_BITS = 32;
    typedef logic [WORD_BITS-1:0] word_t;

    // Byte offsets of decoded registers (behaviour depends on them)
    localparam logic [11:0] OFS_IRQ_STAT = 12'h000;
    localparam logic [11:0] OFS_IRQ_MASK = 12'h004;
    localparam logic [11:0] OFS_RING_LEN = 12'h108;
    localparam logic [11:0] OFS_SETUP_B  = 12'h130;
    localparam logic [11:0] OFS_SETUP_A  = 12'h134;
    localparam logic [11:0] OFS_TRX_CTL  = 12'h144;

    // Control register bit positions
    localparam int CTL_CLR_STAT_BIT   = 1;
    localparam int CTL_FORCE_IDLE_BIT = 2;
    localparam int CTL_IDLE_BIT       = 3;
    localparam int CTL_RING_RST_BIT   = 4;

    localparam word_t CTL_KICK_VALUE = 32'h0000_0001;
    localparam word_t CTL_IDLE_WORD  = 32'h0000_0008;
    localparam word_t SETUP_A_ARM    = 32'h0020_0010;
    localparam word_t SETUP_B_READY  = 32'h8000_0000;

    localparam int RX_LEN_SHIFT = 16;

    typedef struct packed {
        logic mii_evt;
        logic timer;
        logic tx_done;
        logic tx_err;
        logic rx_nobuf;
        logic rx_done;
    } evt_t;

    typedef enum logic [1:0] {
        CA_STORE,
        CA_FORCE_IDLE,
        CA_CLR_STAT,
        CA_ARM_SETUP
    } ctl_act_e;

    typedef struct packed {
        ctl_act_e act;
        logic     kick;
        logic     ring_rst;
    } ctl_dec_t;

    function automatic word_t evt_to_status(evt_t e);
        word_t w;
        w    = '0;
        w[1] = e.rx_done;
        w[2] = e.rx_nobuf;
        w[3] = e.tx_err;
        w[4] = e.tx_done;
        w[5] = e.timer;
        w[6] = e.mii_evt;
        return w;
    endfunction

    // Priority: force-idle ends decoding; then clear-status; then armed zero.
    function automatic ctl_dec_t decode_ctl(word_t v, word_t setup_a);
        ctl_dec_t d;
        d.kick     = (v == CTL_KICK_VALUE);
        d.ring_rst = 1'b0;
        if (v[CTL_FORCE_IDLE_BIT]) begin
            d.act = CA_FORCE_IDLE;
        end else begin
            d.ring_rst = v[CTL_RING_RST_BIT];
            if (v[CTL_CLR_STAT_BIT])
                d.act = CA_CLR_STAT;
            else if (v == '0 && setup_a == SETUP_A_ARM)
                d.act = CA_ARM_SETUP;
            else
                d.act = CA_STORE;
        end
        return d;
    endfunction

    function automatic logic ofs_hit(logic [11:0] byte_addr, logic [11:0] ofs);
        return byte_addr[11:2] == ofs[11:2];
    endfunction

endpackage

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
    import nic_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stat_wr,
    input  logic  mask_wr,
    input  logic  clr_all,
    input  word_t wdata,
    input  word_t evt_bits,
    output word_t status_q,
    output word_t mask_q,
    output logic  irq
);

    word_t status_n;

    always_comb begin
        status_n = status_q;
        if (clr_all)
            status_n = '0;
        else if (stat_wr)
            status_n = status_q & ~wdata;
        status_n = status_n | evt_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_n;
            if (mask_wr)
                mask_q <= wdata;
        end
    end

    assign irq = |(status_q & mask_q);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt_bits != '0) |=> ((status_q & $past(evt_bits)) == $past(evt_bits))); // R4

    AST_W1C_KEEP: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !clr_all && evt_bits == '0)
        |=> ((status_q & ~$past(wdata)) == ($past(status_q) & ~$past(wdata)))); // R3

    AST_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
        (clr_all && evt_bits == '0) |=> (status_q == '0)); // R8

endmodule

// File: rtl/nic_ctl_decode.sv
module nic_ctl_decode
    import nic_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctl_wr,
    input  logic  seta_wr,
    input  logic  setb_wr,
    input  word_t wdata,
    input  logic  dma_busy,
    output word_t ctrl_q,
    output word_t seta_q,
    output word_t setb_q,
    output logic  clr_stat,
    output logic  tx_kick,
    output logic  ring_rst,
    output logic  idle
);

    ctl_dec_t dec;
    word_t    ctrl_n;
    logic     busy_q;
    logic     busy_rise;
    logic     busy_fall;

    assign dec       = decode_ctl(wdata, seta_q);
    assign busy_rise = dma_busy && !busy_q;
    assign busy_fall = !dma_busy && busy_q;
    assign clr_stat  = ctl_wr && (dec.act == CA_CLR_STAT);

    always_comb begin
        ctrl_n = ctrl_q;
        if (ctl_wr) begin
            unique case (dec.act)
                CA_FORCE_IDLE: ctrl_n = CTL_IDLE_WORD;
                CA_STORE:      ctrl_n = wdata;
                default:       ctrl_n = ctrl_q;
            endcase
        end
        if (busy_rise)
            ctrl_n[CTL_IDLE_BIT] = 1'b0;
        else if (busy_fall)
            ctrl_n[CTL_IDLE_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            seta_q   <= '0;
            setb_q   <= '0;
            tx_kick  <= 1'b0;
            ring_rst <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_n;
            tx_kick  <= ctl_wr && dec.kick;
            ring_rst <= ctl_wr && dec.ring_rst;
            busy_q   <= dma_busy;
            if (seta_wr)
                seta_q <= wdata;
            if (setb_wr)
                setb_q <= wdata;
            else if (ctl_wr && dec.act == CA_ARM_SETUP)
                setb_q <= SETUP_B_READY;
        end
    end

    assign idle = ctrl_q[CTL_IDLE_BIT];

    AST_KICK_SRC: assert property (@(posedge clk) disable iff (rst)
        tx_kick |-> $past(ctl_wr && wdata == CTL_KICK_VALUE)); // R5

    AST_FORCE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[CTL_FORCE_IDLE_BIT] && !busy_rise)
        |=> (ctrl_q == CTL_IDLE_WORD)); // R6

    AST_RING_RST_SRC: assert property (@(posedge clk) disable iff (rst)
        ring_rst |-> $past(ctl_wr && wdata[CTL_RING_RST_BIT] && !wdata[CTL_FORCE_IDLE_BIT])); // R7

    AST_ARM_SETUP: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata == '0 && seta_q == SETUP_A_ARM) |=> setb_q[31]); // R9

    AST_IDLE_FALL: assert property (@(posedge clk) disable iff (rst)
        busy_fall |=> idle); // R10

endmodule

// File: rtl/nic_ring_cfg.sv
module nic_ring_cfg
    import nic_csr_pkg::*;
#(
    parameter int RING_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ring_wr,
    input  word_t             wdata,
    output word_t             ring_q,
    output logic [RING_W:0]   tx_len,
    output logic [RING_W:0]   rx_len
);

    localparam int LANES = 2;

    logic [RING_W:0] len [LANES];

    always_ff @(posedge clk) begin
        if (rst)
            ring_q <= '0;
        else if (ring_wr)
            ring_q <= wdata;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int SH = g * RX_LEN_SHIFT;
        assign len[g] = {1'b0, ring_q[SH +: RING_W]} + (RING_W + 1)'(1);
    end

    assign tx_len = len[0];
    assign rx_len = len[1];

    AST_RING_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ring_wr |=> ($stable(tx_len) && $stable(rx_len))); // R11

endmodule

// File: rtl/nic_spare_regs.sv
module nic_spare_regs
    import nic_csr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  word_t            wdata,
    input  logic [IDX_W-1:0] ridx,
    output word_t            rdata
);

    localparam int DEPTH = 1 << IDX_W;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/nic_csr_ctrl.sv
module nic_csr_ctrl
    import nic_csr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RING_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              ev_rx_done,
    input  logic              ev_rx_nobuf,
    input  logic              ev_tx_err,
    input  logic              ev_tx_done,
    input  logic              ev_timer,
    input  logic              ev_mii,
    input  logic              dma_busy,
    output logic              irq,
    output logic              tx_kick,
    output logic              ring_rst,
    output logic              trx_idle,
    output logic [RING_W:0]   tx_ring_len,
    output logic [RING_W:0]   rx_ring_len
);

    localparam int IDX_W = ADDR_W - 2;

    logic [11:0] wa;
    logic [11:0] ra;
    logic        hit_stat, hit_mask, hit_ring, hit_seta, hit_setb, hit_ctl, hit_any;
    evt_t        evt;
    word_t       status_q, mask_q, ctrl_q, seta_q, setb_q, ring_q, spare_rd;
    logic        clr_stat;
    logic        unused_addr_lsb;

    assign wa = 12'(wr_addr);
    assign ra = 12'(rd_addr);
    assign unused_addr_lsb = ^{wr_addr[1:0], rd_addr[1:0]};

    assign hit_stat = wr_en && ofs_hit(wa, OFS_IRQ_STAT);
    assign hit_mask = wr_en && ofs_hit(wa, OFS_IRQ_MASK);
    assign hit_ring = wr_en && ofs_hit(wa, OFS_RING_LEN);
    assign hit_seta = wr_en && ofs_hit(wa, OFS_SETUP_A);
    assign hit_setb = wr_en && ofs_hit(wa, OFS_SETUP_B);
    assign hit_ctl  = wr_en && ofs_hit(wa, OFS_TRX_CTL);
    assign hit_any  = hit_stat | hit_mask | hit_ring | hit_seta | hit_setb | hit_ctl;

    assign evt = '{mii_evt: ev_mii, timer: ev_timer, tx_done: ev_tx_done,
                   tx_err: ev_tx_err, rx_nobuf: ev_rx_nobuf, rx_done: ev_rx_done};

    nic_irq_unit u_irq (
        .clk      (clk),
        .rst      (rst),
        .stat_wr  (hit_stat),
        .mask_wr  (hit_mask),
        .clr_all  (clr_stat),
        .wdata    (wr_data),
        .evt_bits (evt_to_status(evt)),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    nic_ctl_decode u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (hit_ctl),
        .seta_wr  (hit_seta),
        .setb_wr  (hit_setb),
        .wdata    (wr_data),
        .dma_busy (dma_busy),
        .ctrl_q   (ctrl_q),
        .seta_q   (seta_q),
        .setb_q   (setb_q),
        .clr_stat (clr_stat),
        .tx_kick  (tx_kick),
        .ring_rst (ring_rst),
        .idle     (trx_idle)
    );

    nic_ring_cfg #(.RING_W(RING_W)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .ring_wr (hit_ring),
        .wdata   (wr_data),
        .ring_q  (ring_q),
        .tx_len  (tx_ring_len),
        .rx_len  (rx_ring_len)
    );

    nic_spare_regs #(.IDX_W(IDX_W)) u_spare (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && !hit_any),
        .widx  (wr_addr[ADDR_W-1:2]),
        .wdata (wr_data),
        .ridx  (rd_addr[ADDR_W-1:2]),
        .rdata (spare_rd)
    );

    always_comb begin
        if (ofs_hit(ra, OFS_IRQ_STAT))      rd_data = status_q;
        else if (ofs_hit(ra, OFS_IRQ_MASK)) rd_data = mask_q;
        else if (ofs_hit(ra, OFS_RING_LEN)) rd_data = ring_q;
        else if (ofs_hit(ra, OFS_SETUP_A))  rd_data = seta_q;
        else if (ofs_hit(ra, OFS_SETUP_B))  rd_data = setb_q;
        else if (ofs_hit(ra, OFS_TRX_CTL))  rd_data = ctrl_q;
        else                                rd_data = spare_rd;
    end

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != '0)); // R2

endmodule

// File: tb/sim_nic_csr_ctrl.sv
module sim_nic_csr_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ADDR_W = 10;
    localparam int RING_W = 16;
    localparam int DEPTH  = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic              ev_rx_done = 0, ev_rx_nobuf = 0, ev_tx_err = 0;
    logic              ev_tx_done = 0, ev_timer = 0, ev_mii = 0;
    logic              dma_busy = 0;
    logic              irq, tx_kick, ring_rst, trx_idle;
    logic [RING_W:0]   tx_ring_len, rx_ring_len;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit started = 0;

    nic_csr_ctrl #(.ADDR_W(ADDR_W), .RING_W(RING_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_rx_done(ev_rx_done), .ev_rx_nobuf(ev_rx_nobuf), .ev_tx_err(ev_tx_err),
        .ev_tx_done(ev_tx_done), .ev_timer(ev_timer), .ev_mii(ev_mii),
        .dma_busy(dma_busy), .irq(irq), .tx_kick(tx_kick), .ring_rst(ring_rst),
        .trx_idle(trx_idle), .tx_ring_len(tx_ring_len), .rx_ring_len(rx_ring_len)
    );

    always #2 clk = ~clk;

    // Behavioural reference model
    logic [31:0] m_stat, m_mask, m_ctrl, m_ring, m_sa, m_sb;
    logic [31:0] m_mem [DEPTH];
    logic        m_kick, m_rrst, m_busy_q;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_stat = 0; m_mask = 0; m_ctrl = 0; m_ring = 0; m_sa = 0; m_sb = 0;
            m_kick = 0; m_rrst = 0; m_busy_q = 0;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        end else begin
            logic [31:0] ev;
            int w;
            ev = {25'd0, ev_mii, ev_timer, ev_tx_done, ev_tx_err, ev_rx_nobuf, ev_rx_done, 1'b0};
            m_kick = 0; m_rrst = 0;
            w = int'(wr_addr) / 4;
            if (wr_en) begin
                if (w == 0) m_stat = m_stat & ~wr_data;
                else if (w == 1) m_mask = wr_data;
                else if (w == 'h108 / 4) m_ring = wr_data;
                else if (w == 'h134 / 4) m_sa = wr_data;
                else if (w == 'h130 / 4) m_sb = wr_data;
                else if (w == 'h144 / 4) begin
                    if (wr_data == 1) m_kick = 1;
                    if (wr_data[2]) m_ctrl = 32'h8;
                    else begin
                        if (wr_data[4]) m_rrst = 1;
                        if (wr_data[1]) m_stat = 0;
                        else if (wr_data == 0 && m_sa == 32'h0020_0010) m_sb = 32'h8000_0000;
                        else m_ctrl = wr_data;
                    end
                end else m_mem[w] = wr_data;
            end
            m_stat = m_stat | ev;
            if (dma_busy && !m_busy_q) m_ctrl[3] = 0;
            else if (!dma_busy && m_busy_q) m_ctrl[3] = 1;
            m_busy_q = dma_busy;
        end
    end

    function automatic logic [31:0] m_read(input logic [ADDR_W-1:0] a);
        int w;
        w = int'(a) / 4;
        if (w == 0) return m_stat;
        if (w == 1) return m_mask;
        if (w == 'h108 / 4) return m_ring;
        if (w == 'h134 / 4) return m_sa;
        if (w == 'h130 / 4) return m_sb;
        if (w == 'h144 / 4) return m_ctrl;
        return m_mem[w];
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            cycles++;
            cmp("R2 irq", 32'(irq), 32'(|(m_stat & m_mask)));
            cmp("R5 tx_kick", 32'(tx_kick), 32'(m_kick));
            cmp("R7 ring_rst", 32'(ring_rst), 32'(m_rrst));
            cmp("R10 idle", 32'(trx_idle), 32'(m_ctrl[3]));
            cmp("R11 tx_len", 32'(tx_ring_len), {15'd0, 1'b0, m_ring[15:0]} + 1);
            cmp("R11 rx_len", 32'(rx_ring_len), {15'd0, 1'b0, m_ring[31:16]} + 1);
            cmp("R12 rd_data", rd_data, m_read(rd_addr));
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        tick();
        wr_en = 1; wr_addr = ADDR_W'(a); wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        rd_addr = ADDR_W'(a);
        #0.5;
        cmp(tag, rd_data, exp);
    endtask

    task automatic ev_pulse(input logic [5:0] v);
        tick();
        {ev_mii, ev_timer, ev_tx_done, ev_tx_err, ev_rx_nobuf, ev_rx_done} = v;
        tick();
        {ev_mii, ev_timer, ev_tx_done, ev_tx_err, ev_rx_nobuf, ev_rx_done} = '0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        cmp("R1 irq", 32'(irq), 0);
        cmp("R1 idle", 32'(trx_idle), 0);
        cmp("R1 tx_len", 32'(tx_ring_len), 1);
        cmp("R1 rx_len", 32'(rx_ring_len), 1);
        rd_chk("R1 ctrl read", 'h144, 0);
        rd_chk("R1 spare read", 'h3FC, 0);

        // R4 / R2
        wr('h004, 32'h12);
        ev_pulse(6'b000001);
        rd_chk("R4 rx bit1", 'h000, 32'h2);
        cmp("R2 irq set", 32'(irq), 1);
        ev_pulse(6'b111110);
        rd_chk("R4 all sources", 'h000, 32'h7E);
        // R3 clears
        wr('h000, 32'h7C);
        rd_chk("R3 w1c keep", 'h000, 32'h2);
        wr('h000, 32'h2);
        cmp("R2 irq clear", 32'(irq), 0);
        // R3 set wins over clear
        tick();
        wr_en = 1; wr_addr = '0; wr_data = 32'h10; ev_tx_done = 1;
        tick();
        wr_en = 0; ev_tx_done = 0;
        rd_chk("R3 event wins", 'h000, 32'h10);

        // R5 kick
        wr('h144, 32'h1);
        cmp("R5 kick high", 32'(tx_kick), 1);
        tick();
        cmp("R5 kick one cycle", 32'(tx_kick), 0);
        rd_chk("R5 stored", 'h144, 1);
        wr('h144, 32'h11);
        cmp("R5 no kick other value", 32'(tx_kick), 0);
        cmp("R7 ring_rst pulse", 32'(ring_rst), 1);
        tick();
        cmp("R7 ring_rst one cycle", 32'(ring_rst), 0);

        // R8 clear status, ctrl unchanged
        ev_pulse(6'b001000);
        wr('h144, 32'h2);
        rd_chk("R8 status zero", 'h000, 0);
        rd_chk("R8 ctrl kept", 'h144, 32'h11);

        // R6 force idle
        ev_pulse(6'b001000);
        wr('h144, 32'h16);
        rd_chk("R6 ctrl idle word", 'h144, 32'h8);
        cmp("R6 no ring_rst", 32'(ring_rst), 0);
        rd_chk("R6 status kept", 'h000, 32'h10);
        cmp("R10 idle out", 32'(trx_idle), 1);

        // R10 busy edges
        tick(); dma_busy = 1;
        tick();
        cmp("R10 busy clears idle", 32'(trx_idle), 0);
        dma_busy = 0;
        tick();
        cmp("R10 done sets idle", 32'(trx_idle), 1);

        // R9 handshake
        wr('h144, 32'h0);
        rd_chk("R9 zero stored", 'h144, 0);
        wr('h144, 32'h20);
        wr('h134, 32'h0020_0010);
        wr('h144, 32'h0);
        rd_chk("R9 setup flag", 'h130, 32'h8000_0000);
        rd_chk("R9 ctrl kept", 'h144, 32'h20);

        // R11 ring lengths
        wr('h108, 32'h0003_0007);
        cmp("R11 tx len", 32'(tx_ring_len), 8);
        cmp("R11 rx len", 32'(rx_ring_len), 4);
        wr('h108, 32'hFFFF_FFFF);
        cmp("R11 max tx", 32'(tx_ring_len), 32'h10000);
        cmp("R11 max rx", 32'(rx_ring_len), 32'h10000);

        // R12 storage
        wr('h200, 32'hDEAD_BEEF);
        rd_chk("R12 readback", 'h200, 32'hDEAD_BEEF);
        rd_chk("R12 low bits ignored", 'h203, 32'hDEAD_BEEF);
        rd_chk("R12 untouched", 'h1F0, 0);

        // Random phase compared against the model each cycle
        for (int n = 0; n < 3000; n++) begin
            int pick;
            tick();
            pick = $urandom_range(0, 11);
            wr_en = ($urandom_range(0, 2) == 0);
            case (pick)
                0: wr_addr = 'h000;  1: wr_addr = 'h004;  2: wr_addr = 'h108;
                3: wr_addr = 'h130;  4: wr_addr = 'h134;  5: wr_addr = 'h200;
                6: wr_addr = 'h1F0;  default: wr_addr = 'h144;
            endcase
            case ($urandom_range(0, 9))
                0: wr_data = 0;  1: wr_data = 1;  2: wr_data = 2;  3: wr_data = 4;
                4: wr_data = 32'h10; 5: wr_data = 32'h0020_0010; 6: wr_data = 32'h12;
                default: wr_data = $urandom;
            endcase
            {ev_mii, ev_timer, ev_tx_done, ev_tx_err, ev_rx_nobuf, ev_rx_done} =
                ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0;
            if ($urandom_range(0, 5) == 0) dma_busy = ~dma_busy;
            rd_addr = ADDR_W'($urandom_range(0, 7) * 4 + (($urandom_range(0, 1) == 0) ? 'h100 : 'h130));
        end
        tick();
        wr_en = 0;
        tick();
        finish_run();
    end

endmodule